// File: doc/BRIEF.md
# Compare-Based Physical Timer Channel

A register-mapped timer channel placed next to a free-running 64-bit system count. The channel does not count. It stores an absolute 64-bit compare point and keeps checking the registered count against that point. Software can arm the timer in two ways. It can write the compare point directly, as two 32-bit halves. It can also write a signed 32-bit relative delay to the down-counter view, which the channel adds to the live count to form the new compare point.

Reading the down-counter view returns the low word of (compare point − count). The view therefore falls by one for every count step and turns negative once the deadline has passed. This holds whether the timer is enabled or not. A control word holds an enable bit and an interrupt mask bit, and it reports the timer condition as a read-only status bit.

The bus is a single-cycle port with no wait states, using byte addresses of word-aligned registers. A read returns its data on the clock edge that accepts it. The register offsets are:
- 0x020: compare point, low half.
- 0x024: compare point, high half.
- 0x028: down-counter view.
- 0x02C: control word. Bit 0 is enable, bit 1 is mask, bit 2 is status.

Top module: `cmp_timer_chan`

## Requirements
- R1: While and right after reset, the enable and mask bits are 0, the compare point is 0 and `irq_o` is 0.
- R2: A write of value V to offset 0x028 sets the compare point to the registered count plus V sign-extended to 64 bits, with the sum wrapping modulo 2^64.
- R3: A read of offset 0x028 returns bits [31:0] of (compare point − registered count), and `bus_rdata` carries it after the edge that accepts the read.
- R4: With enable set, status (control bit 2) is 1 exactly when (registered count − compare point), read as a signed 64-bit value, is zero or positive. It is evaluated one cycle after its inputs change.
- R5: With enable clear, status and `irq_o` stay 0. The 0x028 view still falls by the amount the count advanced.
- R6: `irq_o` is 1 only when the condition is met, enable is 1 and mask is 0. Setting the mask hides the interrupt but leaves status visible.
- R7: Writes to 0x020 and 0x024 replace that half of the compare point and read back unchanged. The new point governs `irq_o` from the second edge after the write.
- R8: The condition and `irq_o` drop one cycle after a write moves the compare point into the future or clears enable. They are level signals and are not latched.
- R9: Writes to unmapped offsets change no state. Reads of unmapped offsets return 0. A write to control bit 2 has no effect on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_i | input | 64 | Free-running system count |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of a word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, 0 when no read is accepted |
| irq_o | output | 1 | Registered timer interrupt, a level signal |

## Verification
The assertions check the following on every cycle:
- the gating of `irq_o` by enable and mask;
- the absence of the condition while disabled;
- the compare point produced by a relative write;
- the value returned by a view read;
- the reset values.

Only the bench scenarios can show the effects that depend on arithmetic choices. These are the sign extension of negative and extreme delays, wrap-around of the compare sum near the top of the 64-bit range, and the point at which the signed difference changes sign. The scenarios also show the exact cycle at which a direct compare write raises or drops the interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFS_CMP_LO = 'h020;
  localparam int OFS_CMP_HI = 'h024;
  localparam int OFS_TVAL   = 'h028;
  localparam int OFS_CTRL   = 'h02C;

  localparam int BIT_EN   = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_STAT = 2;

  typedef struct packed {
    logic mask;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12,
  localparam int CW = 2 * DW,
  localparam int NW = CW / DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_q,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cmp,
  output ctrl_t         ctrl
);
  logic [CW-1:0] rel_sext;

  // relative delay widened with its sign
  assign rel_sext = {{(CW-DW){wdata[DW-1]}}, wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp  <= '0;
      ctrl <= '0;
    end else if (sel && wr) begin
      if (addr == AW'(OFS_TVAL)) begin
        cmp <= count_q + rel_sext;
      end
      if (addr == AW'(OFS_CTRL)) begin
        ctrl.en   <= wdata[BIT_EN];
        ctrl.mask <= wdata[BIT_MASK];
      end
      for (int w = 0; w < NW; w++) begin
        if (addr == AW'(OFS_CMP_LO + 4 * w)) begin
          cmp[w*DW +: DW] <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_cond.sv
module tmr_cond
  import tmr_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] cmp,
  input  ctrl_t         ctrl,
  output logic [CW-1:0] count_q,
  output logic          cond_q,
  output logic          irq_q
);
  logic [CW-1:0] diff;
  logic          met;

  assign diff = count_q - cmp;
  assign met  = ctrl.en & ~diff[CW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      cond_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_i;
      cond_q  <= met;
      irq_q   <= met & ~ctrl.mask;
    end
  end
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12,
  localparam int CW = 2 * DW,
  localparam int NW = CW / DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] cmp,
  input  logic [CW-1:0] count_q,
  input  ctrl_t         ctrl,
  input  logic          cond_q,
  output logic [DW-1:0] rdata
);
  logic [CW-1:0] remain;
  logic [DW-1:0] word;

  assign remain = cmp - count_q;

  always_comb begin
    word = '0;
    if (addr == AW'(OFS_TVAL)) word = remain[DW-1:0];
    if (addr == AW'(OFS_CTRL)) begin
      word[BIT_EN]   = ctrl.en;
      word[BIT_MASK] = ctrl.mask;
      word[BIT_STAT] = cond_q;
    end
    for (int w = 0; w < NW; w++) begin
      if (addr == AW'(OFS_CMP_LO + 4 * w)) word = cmp[w*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= (sel && !wr) ? word : '0;
  end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_i,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] cmp;
  ctrl_t         ctrl;
  logic          cond_q;

  tmr_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .count_q(count_q),
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cmp(cmp), .ctrl(ctrl)
  );

  tmr_cond #(.CW(CW)) u_cond (
    .clk(clk), .rst(rst), .count_i(count_i), .cmp(cmp), .ctrl(ctrl),
    .count_q(count_q), .cond_q(cond_q), .irq_q(irq_o)
  );

  tmr_rdmux #(.DW(DW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .cmp(cmp), .count_q(count_q), .ctrl(ctrl), .cond_q(cond_q),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12,
  localparam int CW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          sel,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic          cond_q,
  input logic [CW-1:0] count_q,
  input logic [CW-1:0] cmp,
  input ctrl_t         ctrl
);
  // R1: reset clears enable, compare point and interrupt
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!irq && !ctrl.en && !ctrl.mask && cmp == '0));

  // R6: interrupt only when enabled and unmasked in the previous cycle
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl.en && !ctrl.mask));

  // R5: disabled channel never reports the condition
  a_r5_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> !cond_q);

  // R2: relative write lands as count plus signed delay
  a_r2_rel_write: assert property (@(posedge clk) disable iff (rst)
    (sel && wr && addr == AW'(OFS_TVAL)) |=>
      cmp == $past(count_q) + {{(CW-DW){$past(wdata[DW-1])}}, $past(wdata)});

  // R3: view read returns low word of remaining distance
  a_r3_view_read: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr && addr == AW'(OFS_TVAL)) |=>
      rdata == $past(cmp[DW-1:0] - count_q[DW-1:0]));

  // R6: status and interrupt agree when unmasked
  a_r6_irq_vs_status: assert property (@(posedge clk) disable iff (rst)
    irq |-> cond_q);
endmodule

bind cmp_timer_chan tmr_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
  .wdata(bus_wdata), .rdata(bus_rdata), .irq(irq_o), .cond_q(cond_q),
  .count_q(count_q), .cmp(cmp), .ctrl(ctrl)
);

// File: tb/test_cmp_timer_chan.sv
module test_cmp_timer_chan;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int CW = 64;

  localparam logic [AW-1:0] A_LO  = 12'h020;
  localparam logic [AW-1:0] A_HI  = 12'h024;
  localparam logic [AW-1:0] A_TV  = 12'h028;
  localparam logic [AW-1:0] A_CTL = 12'h02C;
  localparam logic [AW-1:0] A_BAD = 12'h030;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] count_i = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmp_timer_chan #(.DW(DW), .AW(AW)) i_cmp_timer_chan (
    .clk(clk), .rst(rst), .count_i(count_i), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic setcnt(input logic [CW-1:0] v);
    @(negedge clk);
    count_i = v;
    idle(2);
  endtask

  task automatic rd_cmp(output logic [CW-1:0] c);
    logic [DW-1:0] lo, hi;
    rd(A_LO, lo);
    rd(A_HI, hi);
    c = {hi, lo};
  endtask

  initial begin
    idle(1000000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    logic [CW-1:0] c, expc, cnt;
    logic [CW-1:0] cnts[4];
    logic [DW-1:0] tvs[7];

    cnts[0] = 64'd0;
    cnts[1] = 64'd1000;
    cnts[2] = 64'hFFFF_FFFF_FFFF_FFF0;
    cnts[3] = 64'h0000_0000_FFFF_FFFE;
    tvs[0] = 32'hFFFF_FFFE; tvs[1] = 32'hFFFF_FFFF; tvs[2] = 32'd0;
    tvs[3] = 32'd1; tvs[4] = 32'd2; tvs[5] = 32'h7FFF_FFFF; tvs[6] = 32'h8000_0000;

    count_i = 64'd500;
    idle(3);
    // R1 reset state
    chk("R1 irq in reset", {63'd0, irq_o}, 64'd0);
    rst = 1'b0;
    idle(1);
    chk("R1 irq after reset", {63'd0, irq_o}, 64'd0);
    rd(A_CTL, r); chk("R1 ctrl", {32'd0, r}, 64'd0);
    rd_cmp(c);    chk("R1 compare", c, 64'd0);
    rd(A_TV, r);  chk("R3 view after reset", {32'd0, r}, {32'd0, 32'd0 - 32'd500});

    // R2 R3 R4 sweep with enable set
    wr(A_CTL, 32'h1);
    for (int ci = 0; ci < 4; ci++) begin
      for (int ti = 0; ti < 7; ti++) begin
        cnt = cnts[ci];
        setcnt(cnt);
        wr(A_TV, tvs[ti]);
        idle(1);
        expc = cnt + {{32{tvs[ti][31]}}, tvs[ti]};
        chk("R4 irq level", {63'd0, irq_o}, {63'd0, ($signed(tvs[ti]) <= 0)});
        rd_cmp(c); chk("R2 compare from view write", c, expc);
        rd(A_TV, r); chk("R3 view read", {32'd0, r}, {32'd0, tvs[ti]});
        rd(A_CTL, r);
        chk("R4 status bit", {63'd0, r[2]}, {63'd0, ($signed(tvs[ti]) <= 0)});
      end
    end

    // R5 disabled: no condition, view keeps falling
    setcnt(64'd2000);
    wr(A_TV, 32'hFFFF_FFF0);
    wr(A_CTL, 32'h0);
    idle(1);
    chk("R5 irq disabled", {63'd0, irq_o}, 64'd0);
    rd(A_CTL, r); chk("R5 status disabled", {32'd0, r}, 64'd0);
    rd(A_TV, r); chk("R5 view before advance", {32'd0, r}, {32'd0, 32'hFFFF_FFF0});
    setcnt(64'd2005);
    rd(A_TV, r); chk("R5 view falls by 5", {32'd0, r}, {32'd0, 32'hFFFF_FFEB});

    // R6 mask hides irq, status remains
    wr(A_CTL, 32'h3);
    idle(1);
    chk("R6 masked irq", {63'd0, irq_o}, 64'd0);
    rd(A_CTL, r); chk("R6 status under mask", {32'd0, r}, 64'd7);
    wr(A_CTL, 32'h1);
    idle(1);
    chk("R6 unmasked irq", {63'd0, irq_o}, 64'd1);

    // R7 direct compare writes and timing
    setcnt(64'd100);
    wr(A_HI, 32'd0);
    wr(A_LO, 32'd200);
    idle(1);
    chk("R7 future compare no irq", {63'd0, irq_o}, 64'd0);
    rd_cmp(c); chk("R7 compare readback", c, 64'd200);
    wr(A_LO, 32'd100);
    chk("R7 irq not yet one edge after write", {63'd0, irq_o}, 64'd0);
    idle(1);
    chk("R7 irq on second edge", {63'd0, irq_o}, 64'd1);
    wr(A_HI, 32'h0000_0001);
    idle(1);
    chk("R7 high half moves compare ahead", {63'd0, irq_o}, 64'd0);
    rd_cmp(c); chk("R7 high half readback", c, 64'h0000_0001_0000_0064);
    wr(A_HI, 32'd0);
    idle(1);

    // R8 condition drops with new compare or disable
    chk("R8 met before move", {63'd0, irq_o}, 64'd1);
    wr(A_TV, 32'd50);
    idle(1);
    chk("R8 cleared by future compare", {63'd0, irq_o}, 64'd0);
    wr(A_TV, 32'd0);
    idle(1);
    chk("R8 met again", {63'd0, irq_o}, 64'd1);
    wr(A_CTL, 32'h0);
    idle(1);
    chk("R8 cleared by disable", {63'd0, irq_o}, 64'd0);

    // R9 unmapped access and read-only status bit
    wr(A_TV, 32'd40);
    wr(A_CTL, 32'h5);
    idle(1);
    rd(A_CTL, r); chk("R9 status write ignored", {32'd0, r}, 64'd1);
    wr(A_BAD, 32'hFFFF_FFFF);
    idle(1);
    rd_cmp(c); chk("R9 unmapped write keeps compare", c, 64'd140);
    rd(A_CTL, r); chk("R9 unmapped write keeps ctrl", {32'd0, r}, 64'd1);
    rd(A_BAD, r); chk("R9 unmapped read zero", {32'd0, r}, 64'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule